// File: doc/BRIEF.md
# Dual-Core Reset Hold Controller

This block decides when each of two processor cores comes out of reset. When the system reset is removed, each core either starts at once or stays parked in reset. An active-low strap per core selects this, and the strap is captured into a per-core hold bit. A parked core is released later by clearing its hold bit. The clear can come over a host-side write port, so an external processor can load memory first. It can also come over a core-side write port, so a core that is already running can start its partner.

The system reset input asserts both core resets at once, with no clock needed. Its removal passes through a synchronizer, so the core resets deassert on a clock edge. Hold bits can only be cleared. Only a new system reset sets them again. Software reads the hold bits back on a zero-extended data bus.

Top module: `coreRunGate`

## Requirements
- R1: While `sysRstN` is low, and for the first two rising clock edges after it goes high, both `coreRst` bits are 1. Writes on either port in that window have no effect.
- R2: A core whose strap is 1 when the synchronized reset ends leaves reset after the second rising edge following the release of `sysRstN`. If both straps are 1, both cores leave reset on that same edge.
- R3: A core whose strap is 0 when the synchronized reset ends keeps its `coreRst` bit at 1 until its hold bit is cleared.
- R4: Strap changes after the synchronized reset has ended do not alter the hold bits or `coreRst`.
- R5: A host write with bit i of `hostWrData` set clears hold bit i on that clock edge. A 0 in bit i leaves hold bit i as it is. Clearing only bit 0 lets core 0 run while core 1 stays held.
- R6: A core-side write clears hold bits with the same per-bit rule as R5. A running core 0 can release core 1 this way.
- R7: When both ports write in the same cycle, the union of the two masks is cleared on that edge.
- R8: Once cleared, a hold bit stays 0 until the next system reset. Once a `coreRst` bit is 0, it stays 0 until the next system reset.
- R9: `holdRdData` bit 0 is core 0's hold bit and bit 1 is core 1's hold bit. All higher bits read 0.
- R10: Driving `sysRstN` low sets both `coreRst` bits and both hold bits to 1 immediately, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | System reset, active low, asynchronous assert |
| strapHoldN | input | NUM_CORES | Per-core hold strap, 0 = stay in reset after system reset |
| hostWrEn | input | 1 | Host-side write strobe |
| hostWrData | input | NUM_CORES | Host-side clear mask, 1 clears a hold bit |
| coreWrEn | input | 1 | Core-side write strobe |
| coreWrData | input | NUM_CORES | Core-side clear mask, 1 clears a hold bit |
| coreRst | output | NUM_CORES | Per-core reset, active high |
| holdRdData | output | DATA_W | Hold bits, zero-extended |

## Verification
The hardest case to reach from the ports is a write that lands inside the two-edge synchronizer window after `sysRstN` rises. There the design is still loading straps, and any write must be dropped. The bench holds a full-mask host write active from before the release through the second edge. It then checks that both cores are still held. A second hard case is an asynchronous reset in the middle of a cycle. The bench drops `sysRstN` between clock edges and samples the outputs one time unit later. Every other cycle is compared against a behavioural model that counts the synchronizer edges.

// File: rtl/crgPkg.sv
package crgPkg;

  // Strobes from the control module to the hold-bit datapath
  typedef struct packed {
    logic loadStraps;  // synchronized reset active: track straps
    logic applyHost;   // host clear mask is valid this cycle
    logic applyCore;   // core clear mask is valid this cycle
  } crgStrobeT;

endpackage

// File: rtl/crgCtrl.sv
module crgCtrl
  import crgPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      sysRstN,
  input  logic      hostWrEn,
  input  logic      coreWrEn,
  output logic      sysRstSync,
  output crgStrobeT strobe
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;

  // Asynchronous assertion, release shifted in as zeros from the LSB
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      syncChain <= '1;
    end else begin
      syncChain <= syncChain << 1;
    end
  end

  assign sysRstSync = syncChain[LAST_STAGE];

  always_comb begin
    strobe.loadStraps = sysRstSync;
    strobe.applyHost  = !sysRstSync && hostWrEn;
    strobe.applyCore  = !sysRstSync && coreWrEn;
  end

  AST_SYNC_RELEASE_STICKS: assert property (@(posedge clk) disable iff (!sysRstN)
    !sysRstSync |=> !sysRstSync); // R1

endmodule

// File: rtl/crgHoldPath.sv
module crgHoldPath
  import crgPkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 sysRstN,
  input  crgStrobeT            strobe,
  input  logic [NUM_CORES-1:0] strapHoldN,
  input  logic [NUM_CORES-1:0] hostWrData,
  input  logic [NUM_CORES-1:0] coreWrData,
  output logic [NUM_CORES-1:0] holdQ,
  output logic [DATA_W-1:0]    rdData
);

  localparam int PAD_W = DATA_W - NUM_CORES;

  logic [NUM_CORES-1:0] clrMask;

  always_comb begin
    clrMask = '0;
    if (strobe.applyHost) clrMask = clrMask | hostWrData;
    if (strobe.applyCore) clrMask = clrMask | coreWrData;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      holdQ <= '1;
    end else if (strobe.loadStraps) begin
      holdQ <= ~strapHoldN;
    end else begin
      holdQ <= holdQ & ~clrMask;
    end
  end

  assign rdData = {{PAD_W{1'b0}}, holdQ};

  AST_STRAP_CAPTURE: assert property (@(posedge clk) disable iff (!sysRstN)
    strobe.loadStraps |=> (holdQ == ~$past(strapHoldN))); // R2

  AST_HOLD_NEVER_SETS: assert property (@(posedge clk) disable iff (!sysRstN)
    !strobe.loadStraps |=> ((holdQ & ~$past(holdQ)) == '0)); // R8

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strobe.loadStraps && !strobe.applyHost && !strobe.applyCore) |=> $stable(holdQ)); // R4

  AST_HOST_CLEARS: assert property (@(posedge clk) disable iff (!sysRstN)
    strobe.applyHost |=> ((holdQ & $past(hostWrData)) == '0)); // R5

  AST_CORE_CLEARS: assert property (@(posedge clk) disable iff (!sysRstN)
    strobe.applyCore |=> ((holdQ & $past(coreWrData)) == '0)); // R6

endmodule

// File: rtl/coreRunGate.sv
module coreRunGate
  import crgPkg::*;
#(
  parameter int NUM_CORES   = 2,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 sysRstN,
  input  logic [NUM_CORES-1:0] strapHoldN,
  input  logic                 hostWrEn,
  input  logic [NUM_CORES-1:0] hostWrData,
  input  logic                 coreWrEn,
  input  logic [NUM_CORES-1:0] coreWrData,
  output logic [NUM_CORES-1:0] coreRst,
  output logic [DATA_W-1:0]    holdRdData
);

  logic                 sysRstSync;
  crgStrobeT            strobe;
  logic [NUM_CORES-1:0] holdQ;

  crgCtrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .hostWrEn  (hostWrEn),
    .coreWrEn  (coreWrEn),
    .sysRstSync(sysRstSync),
    .strobe    (strobe)
  );

  crgHoldPath #(
    .NUM_CORES(NUM_CORES),
    .DATA_W   (DATA_W)
  ) i_path (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .strobe    (strobe),
    .strapHoldN(strapHoldN),
    .hostWrData(hostWrData),
    .coreWrData(coreWrData),
    .holdQ     (holdQ),
    .rdData    (holdRdData)
  );

  for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
    assign coreRst[gi] = sysRstSync | holdQ[gi];

    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!sysRstN)
      !coreRst[gi] |=> !coreRst[gi]); // R8
  end

endmodule

// File: tb/test_coreRunGate.sv
module test_coreRunGate;

  logic        clk = 1'b0;
  logic        sysRstN;
  logic [1:0]  strapHoldN;
  logic        hostWrEn;
  logic [1:0]  hostWrData;
  logic        coreWrEn;
  logic [1:0]  coreWrData;
  logic [1:0]  coreRst;
  logic [31:0] holdRdData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  coreRunGate i_coreRunGate (
    .clk       (clk),
    .sysRstN   (sysRstN),
    .strapHoldN(strapHoldN),
    .hostWrEn  (hostWrEn),
    .hostWrData(hostWrData),
    .coreWrEn  (coreWrEn),
    .coreWrData(coreWrData),
    .coreRst   (coreRst),
    .holdRdData(holdRdData)
  );

  // Behavioural reference: edge counter after release plus a hold word
  int         edgesSinceRel = 0;
  logic [1:0] mHold = 2'b11;

  always @(posedge clk) begin
    logic [1:0] mask;
    if (!sysRstN) begin
      edgesSinceRel = 0;
      mHold = 2'b11;
    end else if (edgesSinceRel < 2) begin
      mHold = ~strapHoldN;
      edgesSinceRel++;
    end else begin
      mask = 2'b00;
      if (hostWrEn) mask = mask | hostWrData;
      if (coreWrEn) mask = mask | coreWrData;
      mHold = mHold & ~mask;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [1:0] expRst;
    @(negedge clk);
    expRst = (!sysRstN || edgesSinceRel < 2) ? 2'b11 : mHold;
    chk({curReq, " model coreRst"}, {30'd0, coreRst}, {30'd0, expRst});
    chk({curReq, " model holdRdData"}, holdRdData, {30'd0, mHold});
  endtask

  task automatic idleWrites();
    hostWrEn = 1'b0; hostWrData = 2'b00;
    coreWrEn = 1'b0; coreWrData = 2'b00;
  endtask

  task automatic resetWith(input logic [1:0] straps);
    sysRstN = 1'b0;
    strapHoldN = straps;
    tick(); tick();
    sysRstN = 1'b1;
    tick(); tick();
  endtask

  initial begin
    sysRstN = 1'b0;
    strapHoldN = 2'b11;
    idleWrites();

    // R1: held during system reset
    curReq = "R1";
    tick(); tick(); tick();
    chk("R1 held in reset", {30'd0, coreRst}, 32'd3);
    sysRstN = 1'b1;
    tick();
    chk("R1 held in sync window", {30'd0, coreRst}, 32'd3);
    // R2: both run together after the second edge
    curReq = "R2";
    tick();
    chk("R2 both released together", {30'd0, coreRst}, 32'd0);
    chk("R9 readback all clear", holdRdData, 32'd0);
    // R4: strap change later is ignored
    curReq = "R4";
    strapHoldN = 2'b00;
    tick(); tick(); tick();
    chk("R4 late strap ignored", {30'd0, coreRst}, 32'd0);

    // Core 0 runs, core 1 held by strap
    curReq = "R3";
    resetWith(2'b01);
    chk("R3 core1 held by strap", {30'd0, coreRst}, 32'd2);
    chk("R9 readback bit1 only", holdRdData, 32'd2);
    curReq = "R4";
    strapHoldN = 2'b11;
    tick(); tick(); tick();
    chk("R4 strap raise ignored", {30'd0, coreRst}, 32'd2);
    curReq = "R5";
    hostWrEn = 1'b1; hostWrData = 2'b00;
    tick();
    chk("R5 zero mask no effect", {30'd0, coreRst}, 32'd2);
    idleWrites();
    curReq = "R6";
    coreWrEn = 1'b1; coreWrData = 2'b10;
    tick();
    chk("R6 core0 releases core1", {30'd0, coreRst}, 32'd0);
    idleWrites();
    tick();

    // Both held, host releases core 0 alone
    curReq = "R3";
    resetWith(2'b00);
    tick(); tick();
    chk("R3 both held", {30'd0, coreRst}, 32'd3);
    curReq = "R5";
    hostWrEn = 1'b1; hostWrData = 2'b01;
    tick();
    chk("R5 host releases core0 only", {30'd0, coreRst}, 32'd2);
    idleWrites();
    tick(); tick();
    chk("R3 core1 still held", {30'd0, coreRst}, 32'd2);
    curReq = "R8";
    coreWrEn = 1'b1; coreWrData = 2'b01;
    tick();
    chk("R8 repeat clear keeps state", {30'd0, coreRst}, 32'd2);
    curReq = "R6";
    coreWrData = 2'b10;
    tick();
    chk("R6 core port clears bit1", {30'd0, coreRst}, 32'd0);
    curReq = "R8";
    hostWrEn = 1'b1; hostWrData = 2'b11; coreWrData = 2'b00;
    tick();
    idleWrites();
    tick(); tick();
    chk("R8 bits stay clear", holdRdData, 32'd0);

    // R7: simultaneous writes
    curReq = "R7";
    resetWith(2'b00);
    hostWrEn = 1'b1; hostWrData = 2'b01;
    coreWrEn = 1'b1; coreWrData = 2'b10;
    tick();
    chk("R7 union of masks", {30'd0, coreRst}, 32'd0);
    idleWrites();
    tick();

    // R1: writes during the sync window are dropped
    curReq = "R1";
    sysRstN = 1'b0;
    strapHoldN = 2'b00;
    hostWrEn = 1'b1; hostWrData = 2'b11;
    coreWrEn = 1'b1; coreWrData = 2'b11;
    tick(); tick();
    sysRstN = 1'b1;
    tick(); tick();
    chk("R1 window writes ignored", {30'd0, coreRst}, 32'd3);
    idleWrites();
    tick();
    chk("R1 still held after window", holdRdData, 32'd3);

    // R10: asynchronous assertion mid-cycle
    curReq = "R10";
    hostWrEn = 1'b1; hostWrData = 2'b11;
    tick();
    idleWrites();
    chk("R10 pre-check running", {30'd0, coreRst}, 32'd0);
    #1 sysRstN = 1'b0;
    #1 chk("R10 async coreRst", {30'd0, coreRst}, 32'd3);
    chk("R10 async hold bits", holdRdData, 32'd3);
    tick();
    strapHoldN = 2'b11;
    sysRstN = 1'b1;
    tick(); tick();
    chk("R2 release after async reset", {30'd0, coreRst}, 32'd0);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule